// File: doc/BRIEF.md
# Interconnect Performance Counter Unit

This block measures traffic in an on-chip interconnect. It has one free-running cycle counter and a set of event counters whose number is a parameter. Each counter is 32 bits wide. Every clock, the block receives a vector of single-cycle event pulses, laid out as 8 source ports of 32 event lines each. An event counter picks one line from that vector with an 8-bit selector code. The upper three bits of the code name the source port and the lower five bits name the event within that port. A code that names an event the port type does not provide never counts.

Software sets up and reads the unit over a simple register bus. A global control word turns all counting on or off and reports how many event counters were built. Each counter has its own 4 KB register window holding:
- the event selector,
- the counter value, which software can preload,
- an enable bit,
- a sticky wrap flag that software clears by writing one.

Each counter drives its own interrupt line straight from its wrap flag.

Top module: `perf_monitor_unit`

## Requirements
- R1: After reset, every counter value, enable bit and wrap flag is 0, the global enable is 0, and every interrupt line is low.
- R2: The global control word is at address 0x0100. Bit 0 is the read/write global enable. Bits 15:11 read back the number of event counters (4 by default, excluding the cycle counter). All other bits read 0.
- R3: Counter n owns the window at n×0x1000. Inside the window, offset 0x0 is the selector (bits 7:0), 0x4 is the value, 0x8 is the enable (bit 0) and 0xC is the wrap flag (bit 0). Read data appears on the read-data port with the valid strobe one cycle after the read request.
- R4: A counter advances only in a cycle when both the global enable and its own enable are 1. Clearing either one freezes its value. Counter 0 advances by one on every such cycle.
- R5: Event counter n advances by one in a cycle where the event line at index src×32+ev is high, where src is selector bits 7:5 and ev is selector bits 4:0. Pulses on any other line do not advance it.
- R6: For src 0 to 4, ev 0x00 to 0x14 are valid. For src 5 to 7, ev 0x00 to 0x11 are valid. A selector outside its range never advances the counter.
- R7: Counter 0 has no selector. Its selector reads 0 and writes to it are ignored.
- R8: A software write to a counter value loads that value. If an advance falls in the same cycle as the write, the written value is kept and the advance is dropped.
- R9: An advance from all ones wraps the counter to 0 and sets its wrap flag.
- R10: Writing 1 to bit 0 of the wrap flag clears it, and writing 0 leaves it unchanged. If a wrap and a clear fall in the same cycle, the flag stays set.
- R11: Interrupt line n is high exactly while wrap flag n is set, and it stays high until software clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse_i | input | 256 | Event lines, source port s occupying bits s×32 to s×32+31 |
| reg_wr_en_i | input | 1 | Register write request |
| reg_rd_en_i | input | 1 | Register read request |
| reg_addr_i | input | 16 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after the request |
| irq_o | output | 5 | Per-counter wrap interrupt, bit 0 for the cycle counter |

## Verification
The event counters are driven four ways:
- a pulse on a neighbouring line first, then on the selected line, which separates correct index arithmetic from an off-by-one in the src×32+ev mapping;
- codes on both sides of the slave and master range limits, which exposes a wrong bound or a swapped port-type split;
- pulses while the global enable is off and while the counter's own enable is off, which shows that each gate acts on its own;
- a preload held against a live pulse and a preload near all ones, which tell write priority apart from wrap handling and flag clearing.

The cycle counter is checked against an exact count of enabled edges.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int unsigned CODE_W      = 8;
  localparam int unsigned SRC_W       = 3;
  localparam int unsigned EVT_W       = 5;
  localparam int unsigned NUM_SRC     = 1 << SRC_W;
  localparam int unsigned EVT_PER_SRC = 1 << EVT_W;
  localparam int unsigned PULSE_W     = NUM_SRC * EVT_PER_SRC;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned SLV_PORTS   = 5;
  localparam logic [EVT_W-1:0] SLV_EV_MAX = 5'h14;
  localparam logic [EVT_W-1:0] MST_EV_MAX = 5'h11;

  localparam logic [11:0] OFS_SEL  = 12'h000;
  localparam logic [11:0] OFS_VAL  = 12'h004;
  localparam logic [11:0] OFS_CTL  = 12'h008;
  localparam logic [11:0] OFS_FLAG = 12'h00C;
  localparam logic [15:0] GCTL_ADDR = 16'h0100;

  typedef struct packed {
    logic              wr_sel;
    logic              wr_val;
    logic              wr_ctl;
    logic              wr_flag;
    logic [DATA_W-1:0] wdata;
  } slice_wr_t;

  function automatic logic [SRC_W-1:0] code_src(input logic [CODE_W-1:0] code);
    return code[CODE_W-1:EVT_W];
  endfunction

  function automatic logic [EVT_W-1:0] code_evt(input logic [CODE_W-1:0] code);
    return code[EVT_W-1:0];
  endfunction

  function automatic logic code_is_valid(input logic [CODE_W-1:0] code);
    logic [SRC_W-1:0] s;
    logic [EVT_W-1:0] e;
    s = code_src(code);
    e = code_evt(code);
    if (32'(s) < SLV_PORTS) return (e <= SLV_EV_MAX);
    else                    return (e <= MST_EV_MAX);
  endfunction

  function automatic logic [CODE_W-1:0] pulse_index(input logic [CODE_W-1:0] code);
    int unsigned idx;
    idx = 32'(code_src(code)) * EVT_PER_SRC + 32'(code_evt(code));
    return idx[CODE_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] gctl_word(input logic en, input logic [4:0] n_evt);
    return {16'b0, n_evt, 10'b0, en};
  endfunction

endpackage

// File: rtl/pmu_evt_select.sv
module pmu_evt_select
  import pmu_pkg::*;
#(
  parameter bit IS_CYCLE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_sel_i,
  input  logic [CODE_W-1:0]  wcode_i,
  input  logic [PULSE_W-1:0] evt_pulse_i,
  output logic [CODE_W-1:0]  sel_code_o,
  output logic               evt_hit_o
);

  generate
    if (IS_CYCLE) begin : g_cycle
      assign sel_code_o = '0;
      assign evt_hit_o  = 1'b1;
    end else begin : g_event
      logic [CODE_W-1:0] sel_q;
      logic              code_ok;
      logic              line_hi;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sel_q <= '0;
        else if (wr_sel_i) sel_q <= wcode_i;
      end

      assign code_ok    = code_is_valid(sel_q);
      assign line_hi    = evt_pulse_i[pulse_index(sel_q)];
      assign sel_code_o = sel_q;
      assign evt_hit_o  = code_ok & line_hi;
    end
  endgenerate

endmodule

// File: rtl/pmu_counter_slice.sv
module pmu_counter_slice
  import pmu_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en_i,
  input  logic             evt_hit_i,
  input  slice_wr_t        wr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_en_o,
  output logic             flag_o,
  output logic             inc_fire_o,
  output logic             wrap_fire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_q;
  logic             flag_q, flag_d;
  logic             clr_req;

  assign inc_fire_o  = glb_en_i & en_q & evt_hit_i & ~wr_i.wr_val;
  assign wrap_fire_o = inc_fire_o & (&cnt_q);
  assign clr_req     = wr_i.wr_flag & wr_i.wdata[0];

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i.wr_val)     cnt_d = wr_i.wdata[CNT_W-1:0];
    else if (inc_fire_o) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    flag_d = flag_q;
    if (wrap_fire_o)  flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      if (wr_i.wr_ctl) en_q <= wr_i.wdata[0];
    end
  end

  assign cnt_o    = cnt_q;
  assign cnt_en_o = en_q;
  assign flag_o   = flag_q;

endmodule

// File: rtl/pmu_reg_if.sv
module pmu_reg_if
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_CNT = 5,
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned ADDR_W  = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en_i,
  input  logic                            rd_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_vals_i,
  input  logic [NUM_CNT-1:0][CODE_W-1:0]  sel_codes_i,
  input  logic [NUM_CNT-1:0]              cnt_ens_i,
  input  logic [NUM_CNT-1:0]              flags_i,
  output logic                            glb_en_o,
  output slice_wr_t [NUM_CNT-1:0]         slice_wr_o,
  output logic [DATA_W-1:0]               rdata_o,
  output logic                            rvalid_o
);

  localparam int unsigned WIN_W = ADDR_W - 12;

  logic [WIN_W-1:0]  win;
  logic [11:0]       ofs;
  logic              gctl_hit;
  logic              glb_en_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  assign win      = addr_i[ADDR_W-1:12];
  assign ofs      = addr_i[11:0];
  assign gctl_hit = (addr_i == ADDR_W'(GCTL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    glb_en_q <= 1'b0;
    else if (wr_en_i && gctl_hit)  glb_en_q <= wdata_i[0];
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CNT; gi++) begin : g_wr
      logic win_hit;
      assign win_hit = wr_en_i && (win == WIN_W'(gi)) && !gctl_hit;
      assign slice_wr_o[gi].wr_sel  = win_hit && (ofs == OFS_SEL);
      assign slice_wr_o[gi].wr_val  = win_hit && (ofs == OFS_VAL);
      assign slice_wr_o[gi].wr_ctl  = win_hit && (ofs == OFS_CTL);
      assign slice_wr_o[gi].wr_flag = win_hit && (ofs == OFS_FLAG);
      assign slice_wr_o[gi].wdata   = wdata_i;
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (gctl_hit) begin
      rd_mux = gctl_word(glb_en_q, 5'(NUM_EVT));
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (win == WIN_W'(i)) begin
          case (ofs)
            OFS_SEL:  rd_mux = DATA_W'(sel_codes_i[i]);
            OFS_VAL:  rd_mux = DATA_W'(cnt_vals_i[i]);
            OFS_CTL:  rd_mux = DATA_W'(cnt_ens_i[i]);
            OFS_FLAG: rd_mux = DATA_W'(flags_i[i]);
            default:  rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign glb_en_o = glb_en_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/perf_monitor_unit.sv
module perf_monitor_unit
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_EVT_CNTRS = 4,
  parameter int unsigned CNT_W         = 32,
  parameter int unsigned ADDR_W        = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PULSE_W-1:0]         evt_pulse_i,
  input  logic                       reg_wr_en_i,
  input  logic                       reg_rd_en_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  output logic [DATA_W-1:0]          reg_rdata_o,
  output logic                       reg_rvalid_o,
  output logic [NUM_EVT_CNTRS:0]     irq_o
);

  localparam int unsigned NUM_CNT = NUM_EVT_CNTRS + 1;

  logic                            glb_en_w;
  slice_wr_t [NUM_CNT-1:0]         slice_wr_w;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_w;
  logic [NUM_CNT-1:0][CODE_W-1:0]  sel_code_w;
  logic [NUM_CNT-1:0]              cnt_en_w;
  logic [NUM_CNT-1:0]              flag_w;
  logic [NUM_CNT-1:0]              evt_hit_w;
  logic [NUM_CNT-1:0]              inc_fire_w;
  logic [NUM_CNT-1:0]              wrap_fire_w;
  logic [NUM_CNT-1:0]              val_wr_w;
  logic [NUM_CNT-1:0]              flag_clr_w;

  pmu_reg_if #(
    .NUM_CNT (NUM_CNT),
    .NUM_EVT (NUM_EVT_CNTRS),
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W)
  ) reg_if_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (reg_wr_en_i),
    .rd_en_i     (reg_rd_en_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .cnt_vals_i  (cnt_w),
    .sel_codes_i (sel_code_w),
    .cnt_ens_i   (cnt_en_w),
    .flags_i     (flag_w),
    .glb_en_o    (glb_en_w),
    .slice_wr_o  (slice_wr_w),
    .rdata_o     (reg_rdata_o),
    .rvalid_o    (reg_rvalid_o)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
      pmu_evt_select #(
        .IS_CYCLE (gi == 0)
      ) sel_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_sel_i    (slice_wr_w[gi].wr_sel),
        .wcode_i     (slice_wr_w[gi].wdata[CODE_W-1:0]),
        .evt_pulse_i (evt_pulse_i),
        .sel_code_o  (sel_code_w[gi]),
        .evt_hit_o   (evt_hit_w[gi])
      );

      pmu_counter_slice #(
        .CNT_W (CNT_W)
      ) slice_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .glb_en_i    (glb_en_w),
        .evt_hit_i   (evt_hit_w[gi]),
        .wr_i        (slice_wr_w[gi]),
        .cnt_o       (cnt_w[gi]),
        .cnt_en_o    (cnt_en_w[gi]),
        .flag_o      (flag_w[gi]),
        .inc_fire_o  (inc_fire_w[gi]),
        .wrap_fire_o (wrap_fire_w[gi])
      );

      assign val_wr_w[gi]   = slice_wr_w[gi].wr_val;
      assign flag_clr_w[gi] = slice_wr_w[gi].wr_flag & slice_wr_w[gi].wdata[0];
    end
  endgenerate

  assign irq_o = flag_w;

endmodule

// File: rtl/perf_monitor_unit_checker.sv
module perf_monitor_unit_checker
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_CNT = 5,
  parameter int unsigned CNT_W   = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           glb_en,
  input logic                           rd_en,
  input logic                           rvalid,
  input logic [NUM_CNT-1:0][CNT_W-1:0]  cnt,
  input logic [NUM_CNT-1:0][CODE_W-1:0] sel_code,
  input logic [NUM_CNT-1:0]             inc_fire,
  input logic [NUM_CNT-1:0]             wrap_fire,
  input logic [NUM_CNT-1:0]             val_wr,
  input logic [NUM_CNT-1:0]             flag_clr,
  input logic [NUM_CNT-1:0]             irq
);

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid); // R3

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CNT; gi++) begin : g_chk
      AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !inc_fire[gi]); // R4

      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(inc_fire[gi]) && !$past(val_wr[gi])) |-> $stable(cnt[gi])); // R4

      AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc_fire[gi]) && !$past(val_wr[gi])) |->
          cnt[gi] == CNT_W'($past(cnt[gi]) + 1'b1)); // R5

      AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_fire[gi] |=> irq[gi]); // R9

      AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr[gi] && !wrap_fire[gi]) |=> !irq[gi]); // R10

      AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[gi]) |-> $past(wrap_fire[gi])); // R11

      if (gi > 0) begin : g_evt
        AST_INVALID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
          !code_is_valid(sel_code[gi]) |-> !inc_fire[gi]); // R6
      end
    end
  endgenerate

endmodule

bind perf_monitor_unit perf_monitor_unit_checker #(
  .NUM_CNT (NUM_EVT_CNTRS + 1),
  .CNT_W   (CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .glb_en    (glb_en_w),
  .rd_en     (reg_rd_en_i),
  .rvalid    (reg_rvalid_o),
  .cnt       (cnt_w),
  .sel_code  (sel_code_w),
  .inc_fire  (inc_fire_w),
  .wrap_fire (wrap_fire_w),
  .val_wr    (val_wr_w),
  .flag_clr  (flag_clr_w),
  .irq       (irq_o)
);

// File: tb/perf_monitor_unit_tb_top.sv
module perf_monitor_unit_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] evt = '0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [15:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         rvalid;
  logic [4:0]   irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  perf_monitor_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_pulse_i  (evt),
    .reg_wr_en_i  (wr_en),
    .reg_rd_en_i  (rd_en),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .reg_rvalid_o (rvalid),
    .irq_o        (irq)
  );

  function automatic logic [15:0] reg_at(input int n, input logic [11:0] ofs);
    return 16'(n * 16'h1000) + 16'(ofs);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input int bit_a, input int bit_b, input int bit_c, input int cycles);
    @(negedge clk);
    if (bit_a >= 0) evt[bit_a] = 1'b1;
    if (bit_b >= 0) evt[bit_b] = 1'b1;
    if (bit_c >= 0) evt[bit_c] = 1'b1;
    repeat (cycles) @(negedge clk);
    evt = '0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) begin
        check("read with no expectation", rdata, 32'hx);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq after reset", 32'(irq), 32'h0);
    reg_read(16'h0100, 32'h0000_2000, "R1 R2 gctl after reset");
    reg_read(reg_at(0, 12'h004), 32'h0, "R1 c0 value");
    reg_read(reg_at(1, 12'h004), 32'h0, "R1 c1 value");
    reg_read(reg_at(1, 12'h00C), 32'h0, "R1 c1 flag");

    // R7 cycle counter has no selector
    reg_write(reg_at(0, 12'h000), 32'h55);
    reg_read(reg_at(0, 12'h000), 32'h0, "R7 c0 selector");

    // R3 window layout
    reg_write(reg_at(1, 12'h000), 32'h43);
    reg_read(reg_at(1, 12'h000), 32'h43, "R3 c1 selector");
    reg_write(reg_at(1, 12'h008), 32'h1);
    reg_read(reg_at(1, 12'h008), 32'h1, "R3 c1 enable");
    reg_write(reg_at(2, 12'h000), 32'h35);
    reg_write(reg_at(3, 12'h000), 32'hD1);
    reg_write(reg_at(4, 12'h000), 32'hD2);
    reg_write(reg_at(2, 12'h008), 32'h1);
    reg_write(reg_at(3, 12'h008), 32'h1);
    reg_write(reg_at(4, 12'h008), 32'h1);

    // R2 global enable
    reg_write(16'h0100, 32'h1);
    reg_read(16'h0100, 32'h0000_2001, "R2 gctl enabled");

    // R5 selected line only (neighbour 68, selected 67)
    pulse(68, -1, -1, 3);
    pulse(67, -1, -1, 5);
    reg_read(reg_at(1, 12'h004), 32'd5, "R5 c1 count");

    // R6 range limits
    pulse(53, 209, 210, 4);
    reg_read(reg_at(2, 12'h004), 32'd0, "R6 slave ev 0x15 rejected");
    reg_read(reg_at(3, 12'h004), 32'd4, "R6 master ev 0x11 accepted");
    reg_read(reg_at(4, 12'h004), 32'd0, "R6 master ev 0x12 rejected");
    reg_write(reg_at(2, 12'h000), 32'h34);
    pulse(52, -1, -1, 2);
    reg_read(reg_at(2, 12'h004), 32'd2, "R6 slave ev 0x14 accepted");

    // R4 global gate and cycle counter
    reg_write(16'h0100, 32'h0);
    pulse(67, -1, -1, 3);
    reg_read(reg_at(1, 12'h004), 32'd5, "R4 c1 frozen by global off");
    reg_write(reg_at(0, 12'h008), 32'h1);
    reg_write(16'h0100, 32'h1);
    repeat (10) @(negedge clk);
    reg_write(16'h0100, 32'h0);
    reg_read(reg_at(0, 12'h004), 32'd12, "R4 c0 cycles counted");
    repeat (5) @(negedge clk);
    reg_read(reg_at(0, 12'h004), 32'd12, "R4 c0 frozen");

    // R8 preload, R9 wrap, R11 interrupt
    reg_write(reg_at(1, 12'h004), 32'hFFFF_FFFE);
    reg_read(reg_at(1, 12'h004), 32'hFFFF_FFFE, "R8 c1 preload");
    reg_write(16'h0100, 32'h1);
    pulse(67, -1, -1, 2);
    reg_read(reg_at(1, 12'h004), 32'h0, "R9 c1 wrapped");
    reg_read(reg_at(1, 12'h00C), 32'h1, "R9 c1 flag set");
    check("R11 irq follows flag", 32'(irq), 32'h2);

    // R8 write beats a same-cycle advance
    @(negedge clk);
    evt[67] = 1'b1;
    reg_write(reg_at(1, 12'h004), 32'd100);
    evt = '0;
    reg_read(reg_at(1, 12'h004), 32'd100, "R8 write wins over advance");

    // R10 flag clearing
    reg_write(reg_at(1, 12'h00C), 32'h0);
    reg_read(reg_at(1, 12'h00C), 32'h1, "R10 write 0 keeps flag");
    check("R11 irq held", 32'(irq[1]), 32'h1);
    reg_write(reg_at(1, 12'h00C), 32'h1);
    reg_read(reg_at(1, 12'h00C), 32'h0, "R10 write 1 clears flag");
    check("R11 irq dropped", 32'(irq[1]), 32'h0);

    // R4 own enable gate
    reg_write(reg_at(1, 12'h008), 32'h0);
    pulse(67, -1, -1, 3);
    reg_read(reg_at(1, 12'h004), 32'd100, "R4 c1 frozen by own enable");

    // R9 cycle counter wrap
    reg_write(16'h0100, 32'h0);
    reg_write(reg_at(0, 12'h004), 32'hFFFF_FFFE);
    reg_write(16'h0100, 32'h1);
    reg_write(16'h0100, 32'h0);
    reg_read(reg_at(0, 12'h004), 32'h0, "R9 c0 wrapped");
    reg_read(reg_at(0, 12'h00C), 32'h1, "R9 c0 flag set");
    check("R11 irq c0", 32'(irq[0]), 32'h1);

    repeat (4) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule